// File: doc/BRIEF.md
# Six-Lane Transmit Serializer with Output-Enable Selection

This block turns six parallel data words into six serial bit streams, one bit per unit interval (UI), and drives one output-enable line per lane toward that lane's pad buffer. The fast bit clock is modelled as a single-cycle enable, `ui_tick`, on the system clock. A new parallel word is captured on the `ui_tick` that ends a frame. A frame is eight UIs in wide mode and two UIs in narrow mode. The output `frame_start` marks the cycle in which the parallel inputs are sampled.

Each lane has a static source select for its high-impedance request:

- **Direct source.** The lane's own tristate input is passed straight to its tristate output through combinational logic. This path has no alignment to the serial data.
- **Enable-word source.** A shared 4-bit write-enable word is inverted, and each of its bits governs two consecutive UIs. The word is sampled one frame ahead of the data it governs, so it must be presented one frame earlier than that data. Every lane that selects this source sees the same serialized value.

Narrow mode combined with any enable-word selection is an illegal setting. It sets a sticky error flag and forces the affected lanes to request high impedance.

Top module: `tx_nib_serializer`

## Requirements
- R1: After reset and until the first frame is loaded, `ser_out` is all 0, `tri_out` is all 1 (1 = high-impedance request) and `cfg_err` is 0.
- R2: In wide mode (`narrow_mode`=0), a word is captured on a `ui_tick` that ends a frame, and `frame_start` is 1 in that same cycle. Lane x's bits `data_in[8x+0]` through `data_in[8x+7]` then appear on `ser_out[x]` in that order, bit 0 first, one per `ui_tick`.
- R3: In cycles without `ui_tick`, `ser_out` holds its value.
- R4: For a lane with `src_sel[x]`=0 (direct), once a frame has been loaded, `tri_out[x]` follows `tri_in[x]` combinationally, in the same cycle, at any UI.
- R5: For a lane with `src_sel[x]`=1 in wide mode, during UIs 2k and 2k+1 of a frame, `tri_out[x]` equals the inverse of bit k of the `wren_in` word that was sampled at the previous frame's capture. Bit 0 of that word governs UIs 0 and 1. All such lanes carry the same value.
- R6: For a lane with `src_sel[x]`=1, during the first frame after reset no enable word exists yet, so `tri_out[x]` is 1.
- R7: In narrow mode (`narrow_mode`=1), a word is captured every second `ui_tick`, and lane x sends only `data_in[8x+0]` and then `data_in[8x+1]`.
- R8: `cfg_err` becomes 1 in the cycle after any cycle with `narrow_mode`=1 and `src_sel`≠0. After that it stays 1 until reset.
- R9: In narrow mode, a lane with `src_sel[x]`=1 has `tri_out[x]`=1 in the same cycle. Lanes with `src_sel[x]`=0 are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ui_tick | input | 1 | UI-rate enable; one serial bit per pulse |
| narrow_mode | input | 1 | 0: 8 UIs per frame, 1: 2 UIs per frame |
| src_sel | input | 6 | Per-lane tristate source, 0 direct, 1 enable word |
| data_in | input | 48 | Lane x word at bits [8x+7:8x] |
| tri_in | input | 6 | Direct tristate request per lane |
| wren_in | input | 4 | Shared write-enable word, one frame ahead of its data |
| ser_out | output | 6 | Serial data per lane |
| tri_out | output | 6 | High-impedance request per lane |
| cfg_err | output | 1 | Sticky illegal-configuration flag |
| frame_start | output | 1 | Inputs are captured in this cycle |

## Verification
The bench builds the block with its default parameters: six lanes, eight-UI wide frames, two-UI narrow frames and a 4-bit enable word. These values put within reach every wide-mode UI position, each of the four enable-word bits, and the one-frame lag of the enable path. Mixed source selections across lanes, idle cycles between ticks, and a direct input that toggles in the middle of a frame show that the two tristate sources are kept apart. Narrow-mode runs cover the two-bit frame and the illegal-setting flag, including that the flag stays set once the cause is removed.

// File: rtl/tx_nib_pkg.sv
package tx_nib_pkg;

    localparam int NUM_LANES   = 6;
    localparam int WIDE_BITS   = 8;
    localparam int NARROW_BITS = 2;
    localparam int UI_PER_EN   = 2;
    localparam int EN_BITS     = WIDE_BITS / UI_PER_EN;
    localparam int CNT_W       = $clog2(WIDE_BITS);

    typedef enum logic {
        SRC_DIRECT = 1'b0,
        SRC_ENWORD = 1'b1
    } tri_src_e;

    typedef enum logic {
        SER_WIDE   = 1'b0,
        SER_NARROW = 1'b1
    } ser_mode_e;

    // Per-cycle frame control, shared by every lane
    typedef struct packed {
        logic load;     // capture parallel inputs
        logic adv;      // advance to next UI inside a frame
        logic en_step;  // advance enable word by one bit (every UI_PER_EN UIs)
    } frame_ctl_t;

    function automatic logic [CNT_W-1:0] last_ui(input ser_mode_e mode);
        return (mode == SER_NARROW) ? CNT_W'(NARROW_BITS - 1) : CNT_W'(WIDE_BITS - 1);
    endfunction

    function automatic logic tri_pick(input tri_src_e sel, input ser_mode_e mode,
                                      input logic loaded, input logic direct,
                                      input logic from_word);
        logic r;
        if (!loaded)                    r = 1'b1;
        else if (sel == SRC_DIRECT)     r = direct;
        else if (mode == SER_NARROW)    r = 1'b1;
        else                            r = from_word;
        return r;
    endfunction

endpackage

// File: rtl/tx_frame_timer.sv
module tx_frame_timer
    import tx_nib_pkg::*;
#(
    parameter int FRAME_MAX = WIDE_BITS,
    localparam int CW = $clog2(FRAME_MAX)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ui_tick,
    input  ser_mode_e  mode,
    output frame_ctl_t ctl,
    output logic       loaded
);
    logic [CW-1:0] ui_cnt;
    logic [CW-1:0] ui_last;
    logic          at_end;

    assign ui_last = CW'(last_ui(mode));
    assign at_end  = (ui_cnt >= ui_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            ui_cnt <= CW'(FRAME_MAX - 1);
            loaded <= 1'b0;
        end else if (ui_tick) begin
            if (at_end) begin
                ui_cnt <= '0;
                loaded <= 1'b1;
            end else begin
                ui_cnt <= ui_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        ctl.load    = ui_tick && at_end;
        ctl.adv     = ui_tick && !at_end;
        ctl.en_step = ui_tick && !at_end && ui_cnt[0];
    end
endmodule

// File: rtl/tx_lane_ser.sv
module tx_lane_ser
    import tx_nib_pkg::*;
#(
    parameter int W = WIDE_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  frame_ctl_t   ctl,
    input  logic [W-1:0] word,
    output logic         ser
);
    logic [W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst)          shreg <= '0;
        else if (ctl.load) shreg <= word;
        else if (ctl.adv)  shreg <= {1'b0, shreg[W-1:1]};
    end

    assign ser = shreg[0];
endmodule

// File: rtl/tx_enword_ser.sv
module tx_enword_ser
    import tx_nib_pkg::*;
#(
    parameter int EB = EN_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  frame_ctl_t    ctl,
    input  logic [EB-1:0] en_word,
    output logic          tri_req
);
    // stage holds the word for the next frame; shreg serves the current one
    logic [EB-1:0] stage;
    logic [EB-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
            shreg <= '0;
        end else if (ctl.load) begin
            stage <= en_word;
            shreg <= stage;
        end else if (ctl.en_step) begin
            shreg <= {1'b0, shreg[EB-1:1]};
        end
    end

    // enable active high -> high-impedance request is its inverse
    assign tri_req = ~shreg[0];
endmodule

// File: rtl/tx_nib_serializer.sv
module tx_nib_serializer
    import tx_nib_pkg::*;
#(
    parameter int LANES = NUM_LANES,
    parameter int WB    = WIDE_BITS,
    parameter int EB    = EN_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ui_tick,
    input  logic              narrow_mode,
    input  logic [LANES-1:0]  src_sel,
    input  logic [LANES*WB-1:0] data_in,
    input  logic [LANES-1:0]  tri_in,
    input  logic [EB-1:0]     wren_in,
    output logic [LANES-1:0]  ser_out,
    output logic [LANES-1:0]  tri_out,
    output logic              cfg_err,
    output logic              frame_start
);
    frame_ctl_t ctl;
    logic       loaded;
    logic       word_tri;
    ser_mode_e  mode;

    assign mode        = ser_mode_e'(narrow_mode);
    assign frame_start = ctl.load;

    tx_frame_timer #(.FRAME_MAX(WB)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .ui_tick(ui_tick),
        .mode   (mode),
        .ctl    (ctl),
        .loaded (loaded)
    );

    tx_enword_ser #(.EB(EB)) u_enword (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .en_word(wren_in),
        .tri_req(word_tri)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        tx_lane_ser #(.W(WB)) u_ser (
            .clk (clk),
            .rst (rst),
            .ctl (ctl),
            .word(data_in[i*WB +: WB]),
            .ser (ser_out[i])
        );

        assign tri_out[i] = tri_pick(tri_src_e'(src_sel[i]), mode, loaded,
                                     tri_in[i], word_tri);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_err <= 1'b0;
        else if ((mode == SER_NARROW) && (|src_sel))
            cfg_err <= 1'b1;
    end
endmodule

// File: rtl/tx_nib_serializer_chk.sv
module tx_nib_serializer_chk #(
    parameter int LANES = 6,
    parameter int WB    = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                ui_tick,
    input logic                narrow_mode,
    input logic [LANES-1:0]    src_sel,
    input logic [LANES*WB-1:0] data_in,
    input logic [LANES-1:0]    tri_out,
    input logic [LANES-1:0]    ser_out,
    input logic                cfg_err,
    input logic                frame_start,
    input logic                loaded
);
    logic [LANES-1:0] first_bits;
    logic [LANES-1:0] word_lanes;

    always_comb begin
        for (int i = 0; i < LANES; i++) first_bits[i] = data_in[i*WB];
        word_lanes = tri_out & src_sel;
    end

    p_idle_outputs_r1: assert property (@(posedge clk) disable iff (rst)
        !loaded |-> (ser_out == '0 && tri_out == '1));

    p_first_bit_r2: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (ser_out == $past(first_bits)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !ui_tick |=> $stable(ser_out));

    p_shared_word_r5: assert property (@(posedge clk) disable iff (rst)
        !narrow_mode |-> (word_lanes == '0 || word_lanes == src_sel));

    p_err_set_r8: assert property (@(posedge clk) disable iff (rst)
        (narrow_mode && src_sel != '0) |=> cfg_err);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

    p_forced_hiz_r9: assert property (@(posedge clk) disable iff (rst)
        narrow_mode |-> ((tri_out & src_sel) == src_sel));
endmodule

bind tx_nib_serializer tx_nib_serializer_chk #(.LANES(LANES), .WB(WB)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ui_tick    (ui_tick),
    .narrow_mode(narrow_mode),
    .src_sel    (src_sel),
    .data_in    (data_in),
    .tri_out    (tri_out),
    .ser_out    (ser_out),
    .cfg_err    (cfg_err),
    .frame_start(frame_start),
    .loaded     (loaded)
);

// File: tb/tx_nib_serializer_tb.sv
module tx_nib_serializer_tb;
    localparam int L  = 6;
    localparam int WB = 8;
    localparam int EB = 4;

    logic            clk = 1'b0;
    logic            rst;
    logic            ui_tick;
    logic            narrow_mode;
    logic [L-1:0]    src_sel;
    logic [L*WB-1:0] data_in;
    logic [L-1:0]    tri_in;
    logic [EB-1:0]   wren_in;
    logic [L-1:0]    ser_out;
    logic [L-1:0]    tri_out;
    logic            cfg_err;
    logic            frame_start;

    int checks = 0;
    int errors = 0;
    logic [EB-1:0] prev_word;
    bit            prev_ok;

    always #5 clk = ~clk;

    tx_nib_serializer u_dut (
        .clk(clk), .rst(rst), .ui_tick(ui_tick), .narrow_mode(narrow_mode),
        .src_sel(src_sel), .data_in(data_in), .tri_in(tri_in), .wren_in(wren_in),
        .ser_out(ser_out), .tri_out(tri_out), .cfg_err(cfg_err),
        .frame_start(frame_start)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic narrow, input logic [L-1:0] sel);
        @(negedge clk);
        rst = 1'b1; ui_tick = 1'b0; narrow_mode = narrow; src_sel = sel;
        data_in = '0; tri_in = '0; wren_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        prev_ok = 1'b0;
        prev_word = '0;
    endtask

    function automatic logic [L-1:0] exp_ser(input logic [L*WB-1:0] d, input int u);
        logic [L-1:0] r;
        for (int i = 0; i < L; i++) r[i] = d[i*WB + u];
        return r;
    endfunction

    function automatic logic [L-1:0] exp_tri(input int u);
        logic [L-1:0] r;
        for (int i = 0; i < L; i++) begin
            if (!src_sel[i])     r[i] = tri_in[i];
            else if (narrow_mode) r[i] = 1'b1;
            else if (!prev_ok)   r[i] = 1'b1;
            else                 r[i] = ~prev_word[u/2];
        end
        return r;
    endfunction

    function automatic string tri_tag();
        if (src_sel == '0)  return "R4 direct tristate";
        if (narrow_mode)    return "R9 forced high-Z";
        if (!prev_ok)       return "R6 first frame high-Z";
        return "R5 enable word tristate";
    endfunction

    // Sends one frame starting at a negedge with ui_tick low; returns likewise.
    task automatic run_frame(input logic [L*WB-1:0] d, input logic [EB-1:0] w,
                             input bit gaps);
        int n;
        string stag;
        n = narrow_mode ? 2 : WB;
        stag = narrow_mode ? "R7 narrow order" : "R2 wide order";
        data_in = d; wren_in = w; ui_tick = 1'b1;
        #1 check("R2 frame_start on capture", 48'(frame_start), 48'(1));
        @(negedge clk);
        ui_tick = 1'b0;
        data_in = ~d; wren_in = ~w;
        for (int u = 0; u < n; u++) begin
            check(stag, 48'(ser_out), 48'(exp_ser(d, u)));
            check(tri_tag(), 48'(tri_out), 48'(exp_tri(u)));
            if (u == 3) begin
                tri_in = ~tri_in;
                #1 check(tri_tag(), 48'(tri_out), 48'(exp_tri(u)));
            end
            if (u < n - 1) begin
                ui_tick = 1'b1;
                #1 check("R2 no capture mid frame", 48'(frame_start), 48'(0));
                @(negedge clk);
                ui_tick = 1'b0;
                if (gaps) begin
                    @(negedge clk);
                    @(negedge clk);
                    check("R3 hold without tick", 48'(ser_out), 48'(exp_ser(d, u + 1)));
                end
            end
        end
        prev_word = w;
        prev_ok = 1'b1;
    endtask

    task automatic test_reset();
        do_reset(1'b0, 6'b101010);
        tri_in = 6'b010101;
        repeat (2) @(negedge clk);
        check("R1 serial idle", 48'(ser_out), 48'(0));
        check("R1 all high-Z", 48'(tri_out), 48'(6'h3F));
        check("R1 no config error", 48'(cfg_err), 48'(0));
    endtask

    task automatic test_wide_direct();
        do_reset(1'b0, 6'b000000);
        tri_in = 6'b110010;
        run_frame(48'hA5_3C_0F_F0_81_7E, 4'h0, 1'b0);
        run_frame(48'h12_34_56_78_9A_BC, 4'h0, 1'b1);
        run_frame(48'hFF_00_55_AA_01_80, 4'h0, 1'b0);
    endtask

    task automatic test_wide_word();
        do_reset(1'b0, 6'b101001);
        tri_in = 6'b011010;
        run_frame(48'hC3_96_69_3C_E7_18, 4'b0110, 1'b0);
        run_frame(48'h5A_A5_F0_0F_CC_33, 4'b1001, 1'b1);
        run_frame(48'h01_02_04_08_10_20, 4'b0011, 1'b0);
        run_frame(48'h80_40_20_10_08_04, 4'b1110, 1'b0);
        check("R8 no error in wide mode", 48'(cfg_err), 48'(0));
    endtask

    task automatic test_narrow();
        do_reset(1'b1, 6'b000000);
        tri_in = 6'b100001;
        run_frame(48'h01_02_03_00_03_02, 4'h0, 1'b0);
        run_frame(48'hFE_FD_FC_FF_FC_FD, 4'h0, 1'b1);
        check("R8 no error without word lanes", 48'(cfg_err), 48'(0));
    endtask

    task automatic test_cfg_err();
        do_reset(1'b1, 6'b000000);
        tri_in = 6'b000000;
        run_frame(48'h03_01_02_00_03_01, 4'h0, 1'b0);
        src_sel = 6'b000100;
        #1 check("R9 forced high-Z same cycle", 48'(tri_out), 48'(6'b000100));
        check("R8 flag not yet set", 48'(cfg_err), 48'(0));
        @(negedge clk);
        check("R8 flag set next cycle", 48'(cfg_err), 48'(1));
        src_sel = 6'b000000;
        repeat (3) @(negedge clk);
        check("R8 flag sticky", 48'(cfg_err), 48'(1));
        check("R4 lane returns to direct", 48'(tri_out), 48'(6'b000000));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; ui_tick = 1'b0; narrow_mode = 1'b0; src_sel = '0;
        data_in = '0; tri_in = '0; wren_in = '0;
        test_reset();
        test_wide_direct();
        test_wide_word();
        test_narrow();
        test_cfg_err();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule